// File: doc/BRIEF.md
# Stored-Address Two-Level Select Decoder

This block turns a six-bit address into sixty-four mutually exclusive, active-high select lines. It is assembled from identical three-bit decoder slices. Each slice has a private address register that is either loading or holding, and a pair of output gates: one active-low and one active-high. A root slice decodes the upper three address bits. Each of its eight outputs opens the high-true gate of one leaf slice, and that leaf decodes the lower three bits.

All slices share a single hold control. While hold is low, the address registers reload on every clock, so the selects follow the address one cycle later. Once hold is high, the registers keep the last address loaded, and later address activity is ignored. A global active-low strobe and a global high-true enable drive the root slice's gates. They act combinationally, so they can blank or restore all sixty-four lines in the same cycle, whatever the register state. A synchronous active-low reset clears every stored address to zero.

Top module: `sel_tree_decoder`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the stored address to 0. After reset, with the gates open and hold high, only sel[0] is high.
- R2: While latch_hold is low at a clock edge, the address on addr is stored at that edge. From then on, sel shows that address.
- R3: While latch_hold is high at a clock edge, the stored address does not change, whatever addr does.
- R4: On the first clock edge with latch_hold high, the stored value is the address taken at the last edge that had latch_hold low.
- R5: sel is all zero unless strobe_n is 0 and enable_hi is 1.
- R6: strobe_n and enable_hi change sel in the same cycle, without a clock edge, and have no effect on the stored address. Reopening the gates while holding shows the held address again.
- R7: sel has at most one bit set in every cycle.
- R8: With the gates open, exactly one bit is high. Its index equals the stored address read as an unsigned binary number, with addr[0] as the least significant bit. addr[5:3] picks the group of eight and addr[2:0] picks the line within the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| latch_hold | input | 1 | 0: load the address each clock; 1: hold the stored address |
| addr | input | 6 | Address to decode |
| strobe_n | input | 1 | Global active-low strobe |
| enable_hi | input | 1 | Global active-high enable |
| sel | output | 64 | One-hot select lines, active high |

## Verification
Gate changes and address holding can fall in the same cycle: strobe_n or enable_hi can toggle in the very cycle that latch_hold rises, or while it stays high and addr changes. The bench provokes this with directed hold windows and with random stimulus in which hold, address and gates all change independently on each cycle. It judges each cycle against a shadow address that it updates only at edges where hold was low. The expected select pattern is then computed from that shadow address and the gate values present in that cycle.

// File: rtl/sel_tree_pkg.sv
// Shared helpers for the select decoder tree.
// Assumes: slice address widths small enough for a shifted one-hot.
package sel_tree_pkg;
    localparam int SLICE_AW_DEF = 3;

    // One-hot decode of a slice address into 2**AW lines.
    function automatic logic [(1<<SLICE_AW_DEF)-1:0] onehot3(input logic [SLICE_AW_DEF-1:0] a);
        logic [(1<<SLICE_AW_DEF)-1:0] v;
        v = '0;
        v[a] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/dec_slice.sv
// One decoder slice: address register that loads when hold is low,
// followed by a one-hot decoder gated by an active-low and an
// active-high enable. Assumes: rst_n is synchronous, active low.
module dec_slice #(
    parameter int AW = 3,
    localparam int NO = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [AW-1:0] a_in,
    input  logic          gate_n,
    input  logic          gate_p,
    output logic [NO-1:0] y
);
    logic [AW-1:0] a_q;
    logic [NO-1:0] dec;

    // Address register: load while hold is low, keep while high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_q <= '0;
        else if (!hold)
            a_q <= a_in;
    end

    // Decode the stored address into one line.
    always_comb begin
        dec = '0;
        dec[a_q] = 1'b1;
    end

    // Output gate, independent of the register state.
    assign y = (!gate_n && gate_p) ? dec : '0;

    // R7: a slice never raises two lines.
    assert_slice_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(y));

    // R3: the stored address is left alone while holding.
    assert_slice_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && gate_p && !gate_n) |=> ((gate_p && !gate_n) -> $stable(y)));
endmodule

// File: rtl/sel_tree_decoder.sv
// Two-level stored-address decoder: a root slice decodes the upper
// address bits and gates one leaf slice per output; leaves decode the
// lower bits. All slices share the hold control. Assumes the address
// width is twice the slice width.
module sel_tree_decoder #(
    parameter int SLICE_AW = 3,
    localparam int ADDR_W = 2 * SLICE_AW,
    localparam int NUM_LEAF = 1 << SLICE_AW,
    localparam int OUT_W = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_n,
    input  logic              enable_hi,
    output logic [OUT_W-1:0]  sel
);
    logic [NUM_LEAF-1:0] root_y;
    logic                gates_open;

    // Root slice: upper bits, gated by the global strobe and enable.
    dec_slice #(.AW(SLICE_AW)) u_root (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (latch_hold),
        .a_in   (addr[ADDR_W-1:SLICE_AW]),
        .gate_n (strobe_n),
        .gate_p (enable_hi),
        .y      (root_y)
    );

    // Leaf slices: lower bits, each opened by one root line.
    for (genvar g = 0; g < NUM_LEAF; g++) begin : g_leaf
        dec_slice #(.AW(SLICE_AW)) u_leaf (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (latch_hold),
            .a_in   (addr[SLICE_AW-1:0]),
            .gate_n (1'b0),
            .gate_p (root_y[g]),
            .y      (sel[g*NUM_LEAF +: NUM_LEAF])
        );
    end

    // Global gate condition, used by the checks below.
    assign gates_open = !strobe_n && enable_hi;

    // R7: at most one of all outputs high.
    assert_tree_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R5: closed gates blank every line.
    assert_gate_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gates_open |-> (sel == '0));

    // R2 / R8: an address loaded with hold low shows on its own line.
    assert_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_hold |=> (!gates_open || sel[$past(addr)]));

    // R3: held address keeps the same line while gates stay open.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_hold && gates_open) |=> (gates_open -> $stable(sel)));
endmodule

// File: tb/tb_sel_tree_decoder.sv
module tb_sel_tree_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        latch_hold;
    logic [5:0]  addr;
    logic        strobe_n;
    logic        enable_hi;
    logic [63:0] sel;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [5:0] shadow;

    sel_tree_decoder dut (
        .clk(clk), .rst_n(rst_n), .latch_hold(latch_hold), .addr(addr),
        .strobe_n(strobe_n), .enable_hi(enable_hi), .sel(sel)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] expect_sel(input logic [5:0] a, input logic sn, input logic eh);
        return (!sn && eh) ? (64'd1 << a) : 64'd0;
    endfunction

    task automatic check(input string tag);
        logic [63:0] e;
        e = expect_sel(shadow, strobe_n, enable_hi);
        checks++;
        if (sel !== e) begin
            errors++;
            $display("FAIL %s sel=%h expected=%h", tag, sel, e);
        end
    endtask

    // Drive at falling edge, clock once, update shadow, sample after edge.
    task automatic step(input logic r, input logic h, input logic [5:0] a,
                        input logic sn, input logic eh, input string tag);
        @(negedge clk);
        rst_n = r; latch_hold = h; addr = a; strobe_n = sn; enable_hi = eh;
        @(posedge clk);
        if (!r) shadow = 6'd0;
        else if (!h) shadow = a;
        #1 check(tag);
    endtask

    // Change only the gates, no clock edge, check at once.
    task automatic gate_now(input logic sn, input logic eh, input string tag);
        #1 strobe_n = sn; enable_hi = eh;
        #1 check(tag);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        rst_n = 0; latch_hold = 1; addr = 6'd45; strobe_n = 0; enable_hi = 1;
        shadow = 6'd0;
        // R1: reset clears the stored address.
        step(0, 1, 6'd45, 0, 1, "R1");
        step(1, 1, 6'd45, 0, 1, "R1");
        // R2 / R8: follow mode across groups and line indices.
        step(1, 0, 6'd0,  0, 1, "R8");
        step(1, 0, 6'd7,  0, 1, "R8");
        step(1, 0, 6'd8,  0, 1, "R8");
        step(1, 0, 6'd63, 0, 1, "R8");
        step(1, 0, 6'd42, 0, 1, "R2");
        // R4: hold rises with a new address; the old one is kept.
        step(1, 0, 6'd19, 0, 1, "R2");
        step(1, 1, 6'd50, 0, 1, "R4");
        // R3: address changes during hold are ignored.
        step(1, 1, 6'd3,  0, 1, "R3");
        step(1, 1, 6'd60, 0, 1, "R3");
        // R6 / R5: gates toggle while holding, take effect at once.
        gate_now(1, 1, "R6");
        gate_now(0, 0, "R6");
        gate_now(1, 0, "R5");
        gate_now(0, 1, "R6");
        step(1, 1, 6'd33, 1, 1, "R5");
        step(1, 1, 6'd33, 0, 1, "R6");
        // Release hold with gates closed, then open.
        step(1, 0, 6'd12, 0, 0, "R5");
        gate_now(0, 1, "R2");
        // R1: reset while holding clears to 0.
        step(0, 1, 6'd9, 0, 1, "R1");
        step(1, 1, 6'd9, 0, 1, "R1");
        // Random mix; R7 is judged by the same one-hot comparison.
        for (int i = 0; i < 400; i++) begin
            logic h, sn, eh;
            logic [5:0] a;
            string tag;
            h  = ($urandom % 3) != 0;
            a  = 6'($urandom);
            sn = ($urandom % 4) == 0;
            eh = ($urandom % 4) != 0;
            if (sn || !eh) tag = "R5";
            else if (h) tag = "R3";
            else tag = "R7";
            step(1, h, a, sn, eh, tag);
            if (($urandom % 5) == 0) gate_now(~sn, eh, "R6");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule